// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A watchdog for a system controller. Software programs two 20-bit preload values over a small single-cycle register bus. Once enabled, a down counter runs through stage 1. When stage 1 runs out, an interrupt may be raised and stage 2 begins. If stage 2 also runs out, a one-cycle reset request can be issued. Software keeps the system alive by periodically restarting stage 1, which is called a kick.

The preload registers and the reload register are guarded by a two-write magic key. The key is used up by the next guarded write, so each protected access needs a fresh key pair. A lock bit freezes the enable setting until reset. A sticky timeout flag records that a watchdog reset happened. It is kept across the system reset input, and only the power-on reset clears it.

Each preload count lasts 2^PRESCALE_W input clocks. The preload is placed above PRESCALE_W zero bits in one wide down counter.

Top module: `wdt_two_stage`

## Requirements
- R1: After power-on reset, both preload registers (0x00, 0x04) read 0xFFFFF. The reload register (0x0C) reads 0x100. The lock register (0x14) reads 0. The status register (0x08) reads 0. The configuration register (0x10) reads 0x3. irq_o and rst_req_o are low.
- R2: An accepted preload write stores only bits 19:0 of the write data. Reading 0x00 or 0x04 returns the stored value in bits 19:0. A preload write is accepted only while the key is open; otherwise it changes nothing.
- R3: The key is compared against bits 15:0 of writes to 0x0C. Writing 0x0080 and then 0x0086 opens the key. Writing 0x0086 without a preceding 0x0080 does not open it. The first write to 0x00, 0x04 or 0x0C after the key opens is accepted, and that write closes the key again.
- R4: An accepted reload write with bit 8 set restarts stage 1 from the stage-1 preload. An accepted reload write with bit 9 set clears the sticky timeout flag.
- R5: A stage loaded with preload P expires, and its effect is visible, P*2^PRESCALE_W+1 clock cycles after the clock edge that loaded it.
- R6: When stage 1 expires with the interrupt enabled, irq_o rises and status bit 0 reads 1. Whether or not the interrupt is enabled, the counter then loads the stage-2 preload, and reload read bit 8 becomes 0.
- R7: When stage 2 expires with reboot enabled, rst_req_o is high for exactly one cycle. In the same cycle the sticky flag is set, and the block returns to stage 1 reloaded from the stage-1 preload.
- R8: When stage 2 expires with reboot disabled, there is no reset request and the sticky flag is unchanged. Counting continues in stage 1.
- R9: The sticky flag reads in bit 9 of 0x0C. It survives sys_rst_ni, which resets everything else. It is cleared by rst_ni.
- R10: Writing 1 to status bit 0 clears the interrupt and drops irq_o. Status bit 0 reads 1 only while the interrupt is both enabled and active.
- R11: The lock register holds lock in bit 0 and enable in bit 1. Once lock is set, writes to it are ignored until reset. An enable change from 0 to 1 starts stage 1 from the stage-1 preload. Enable at 0 holds the counter.
- R12: In the configuration register at 0x10, reboot is enabled when bit 5 is 0, and the interrupt is enabled when bits 1:0 are both 0. A read returns bit 5 and bits 1:0 as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| sys_rst_ni | input | 1 | System reset, active low, asynchronous; clears all but the sticky flag |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high with req_i |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| irq_o | output | 1 | Stage-1 interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with PRESCALE_W set to 2, so each preload count lasts four clocks. With that setting, stage lengths of small preloads such as 3 and 2 take 13 and 9 cycles. This makes exact cycle counts for interrupt and reset timing reachable within a short run. PRELOAD_W and DATA_W keep their defaults, so the 20-bit masking and the key compare are exercised at full width.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {STG_ONE = 1'b0, STG_TWO = 1'b1} stage_e;
  typedef enum logic [1:0] {UL_IDLE = 2'd0, UL_HALF = 2'd1, UL_OPEN = 2'd2} unlock_e;

  localparam logic [4:0] OFS_PRE1   = 5'h00;
  localparam logic [4:0] OFS_PRE2   = 5'h04;
  localparam logic [4:0] OFS_STAT   = 5'h08;
  localparam logic [4:0] OFS_RELOAD = 5'h0C;
  localparam logic [4:0] OFS_CFG    = 5'h10;
  localparam logic [4:0] OFS_LOCK   = 5'h14;

  localparam logic [15:0] KEY_FIRST  = 16'h0080;
  localparam logic [15:0] KEY_SECOND = 16'h0086;

  localparam int BIT_KICK    = 8;
  localparam int BIT_TIMEOUT = 9;
  localparam int BIT_NOBOOT  = 5;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rl_wr_i,
  input  logic        pre_wr_i,
  input  logic [15:0] key_i,
  output logic        open_o,
  output logic        grant_o
);
  unlock_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    grant_o = 1'b0;
    if (rl_wr_i) begin
      if (key_i == KEY_FIRST) st_d = UL_HALF;
      else if (key_i == KEY_SECOND && st_q == UL_HALF) st_d = UL_OPEN;
      else if (st_q == UL_OPEN) begin
        grant_o = 1'b1;
        st_d    = UL_IDLE;
      end
    end else if (pre_wr_i && st_q == UL_OPEN) begin
      st_d = UL_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= UL_IDLE;
    else         st_q <= st_d;

  assign open_o = (st_q == UL_OPEN);
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int PRELOAD_W  = 20,
  parameter int PRESCALE_W = 15
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic [PRELOAD_W-1:0]            val_i,
  input  logic                            run_i,
  output logic                            zero_o,
  output logic [PRELOAD_W+PRESCALE_W-1:0] cnt_o
);
  localparam int CNT_W = PRELOAD_W + PRESCALE_W;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= {val_i, {PRESCALE_W{1'b0}}};
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);

  assign zero_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/wdt_stage_ctrl.sv
module wdt_stage_ctrl
  import wdt_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   restart_i,
  input  logic   expire_i,
  input  logic   intr_en_i,
  input  logic   reboot_en_i,
  input  logic   irq_clr_i,
  output stage_e stage_o,
  output logic   load_o,
  output logic   sel_two_o,
  output logic   intr_act_o,
  output logic   req_set_o,
  output logic   rst_req_o
);
  stage_e stage_q, stage_d;
  logic   act_q, set_act;

  always_comb begin
    stage_d   = stage_q;
    load_o    = 1'b0;
    sel_two_o = 1'b0;
    set_act   = 1'b0;
    req_set_o = 1'b0;
    if (restart_i) begin
      load_o  = 1'b1;
      stage_d = STG_ONE;
    end else if (expire_i) begin
      load_o = 1'b1;
      if (stage_q == STG_ONE) begin
        stage_d   = STG_TWO;
        sel_two_o = 1'b1;
        set_act   = intr_en_i;
      end else begin
        stage_d   = STG_ONE;
        req_set_o = reboot_en_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      stage_q   <= STG_ONE;
      act_q     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      stage_q   <= stage_d;
      rst_req_o <= req_set_o;
      if (set_act)        act_q <= 1'b1;
      else if (irq_clr_i) act_q <= 1'b0;
    end

  assign stage_o    = stage_q;
  assign intr_act_o = act_q;
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int PRELOAD_W  = 20,
  parameter int PRESCALE_W = 15,
  parameter int DATA_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [4:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int CNT_W = PRELOAD_W + PRESCALE_W;

  logic core_rst_n;
  assign core_rst_n = rst_ni & sys_rst_ni;

  logic wr, rl_wr, pre_any_wr, ul_open, ul_grant;
  assign wr         = req_i & we_i;
  assign rl_wr      = wr && addr_i == OFS_RELOAD;
  assign pre_any_wr = wr && (addr_i == OFS_PRE1 || addr_i == OFS_PRE2);

  wdt_unlock u_unlock (
    .clk_i    (clk_i),
    .rst_ni   (core_rst_n),
    .rl_wr_i  (rl_wr),
    .pre_wr_i (pre_any_wr),
    .key_i    (wdata_i[15:0]),
    .open_o   (ul_open),
    .grant_o  (ul_grant)
  );

  logic [PRELOAD_W-1:0] pre_q [2];
  for (genvar g = 0; g < 2; g++) begin : g_pre
    logic [PRELOAD_W-1:0] q;
    logic                 hit;
    assign hit = wr && ul_open && addr_i == OFS_PRE1 + 5'(4 * g);
    always_ff @(posedge clk_i or negedge core_rst_n)
      if (!core_rst_n) q <= '1;
      else if (hit)    q <= wdata_i[PRELOAD_W-1:0];
    assign pre_q[g] = q;
  end

  // configuration and lock/enable
  logic       reboot_dis_q, locked_q, en_q;
  logic [1:0] int_type_q;
  logic       cfg_wr, lock_wr, en_start;
  assign cfg_wr   = wr && addr_i == OFS_CFG;
  assign lock_wr  = wr && addr_i == OFS_LOCK && !locked_q;
  assign en_start = lock_wr && wdata_i[1] && !en_q;

  always_ff @(posedge clk_i or negedge core_rst_n)
    if (!core_rst_n) begin
      reboot_dis_q <= 1'b0;
      int_type_q   <= 2'b11;
      locked_q     <= 1'b0;
      en_q         <= 1'b0;
    end else begin
      if (cfg_wr) begin
        reboot_dis_q <= wdata_i[BIT_NOBOOT];
        int_type_q   <= wdata_i[1:0];
      end
      if (lock_wr) begin
        locked_q <= wdata_i[0];
        en_q     <= wdata_i[1];
      end
    end

  logic intr_en, kick, irq_clr, sticky_clr;
  assign intr_en    = (int_type_q == 2'b00);
  assign kick       = ul_grant && wdata_i[BIT_KICK];
  assign sticky_clr = ul_grant && wdata_i[BIT_TIMEOUT];
  assign irq_clr    = wr && addr_i == OFS_STAT && wdata_i[0];

  // counter and stage sequencing
  logic             cnt_zero, cnt_load, sel_two, intr_act, req_set, expire;
  logic [CNT_W-1:0] cnt;
  stage_e           stage;
  assign expire = en_q && cnt_zero;

  wdt_stage_ctrl u_stage (
    .clk_i       (clk_i),
    .rst_ni      (core_rst_n),
    .restart_i   (kick | en_start),
    .expire_i    (expire),
    .intr_en_i   (intr_en),
    .reboot_en_i (!reboot_dis_q),
    .irq_clr_i   (irq_clr),
    .stage_o     (stage),
    .load_o      (cnt_load),
    .sel_two_o   (sel_two),
    .intr_act_o  (intr_act),
    .req_set_o   (req_set),
    .rst_req_o   (rst_req_o)
  );

  wdt_down_counter #(.PRELOAD_W(PRELOAD_W), .PRESCALE_W(PRESCALE_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (core_rst_n),
    .load_i (cnt_load),
    .val_i  (sel_two ? pre_q[1] : pre_q[0]),
    .run_i  (en_q),
    .zero_o (cnt_zero),
    .cnt_o  (cnt)
  );

  // sticky timeout flag: cleared only by power-on reset
  logic sticky_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         sticky_q <= 1'b0;
    else if (req_set)    sticky_q <= 1'b1;
    else if (sticky_clr) sticky_q <= 1'b0;

  logic stage_is_two;
  assign stage_is_two = (stage == STG_TWO);
  assign irq_o        = intr_act && intr_en;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_PRE1:   rdata_o[PRELOAD_W-1:0] = pre_q[0];
      OFS_PRE2:   rdata_o[PRELOAD_W-1:0] = pre_q[1];
      OFS_STAT:   rdata_o[0] = intr_act && intr_en;
      OFS_RELOAD: begin
        rdata_o[BIT_TIMEOUT] = sticky_q;
        rdata_o[BIT_KICK]    = !stage_is_two;
      end
      OFS_CFG: begin
        rdata_o[BIT_NOBOOT] = reboot_dis_q;
        rdata_o[1:0]        = int_type_q;
      end
      OFS_LOCK:   rdata_o[1:0] = {en_q, locked_q};
      default:    rdata_o = '0;
    endcase
  end

  logic bits_unused;
  assign bits_unused = ^wdata_i;
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int CNT_W = 35
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sys_rst_ni,
  input logic             rst_req_i,
  input logic             sticky_i,
  input logic             en_i,
  input logic             locked_i,
  input logic             reboot_dis_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             load_i,
  input logic             intr_act_i,
  input logic             stage2_i
);
  a_r7_req_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni || !sys_rst_ni)
    rst_req_i |=> !rst_req_i);

  a_r9_req_sets_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni || !sys_rst_ni)
    rst_req_i |-> sticky_i);

  a_r8_req_needs_reboot: assert property (@(posedge clk_i) disable iff (!rst_ni || !sys_rst_ni)
    rst_req_i |-> !$past(reboot_dis_i));

  a_r11_lock_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni || !sys_rst_ni)
    locked_i |=> locked_i && $stable(en_i));

  a_r11_idle_holds_count: assert property (@(posedge clk_i) disable iff (!rst_ni || !sys_rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_i));

  a_r6_irq_enters_stage2: assert property (@(posedge clk_i) disable iff (!rst_ni || !sys_rst_ni)
    $rose(intr_act_i) |-> stage2_i);
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CNT_W(PRELOAD_W + PRESCALE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sys_rst_ni   (sys_rst_ni),
  .rst_req_i    (rst_req_o),
  .sticky_i     (sticky_q),
  .en_i         (en_q),
  .locked_i     (locked_q),
  .reboot_dis_i (reboot_dis_q),
  .cnt_i        (cnt),
  .load_i       (cnt_load),
  .intr_act_i   (intr_act),
  .stage2_i     (stage_is_two)
);

// File: tb/sim_wdt_two_stage.sv
`timescale 1ns/1ps
module sim_wdt_two_stage;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;

  logic        clk = 1'b0, rst_ni = 1'b0, sys_rst_ni = 1'b1;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, rst_req_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_two_stage #(.PRELOAD_W(20), .PRESCALE_W(2), .DATA_W(32)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sys_rst_ni(sys_rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0, irq_seen = 0;

  // {req tag, we, addr, data, expected read}
  localparam logic [73:0] VEC [NV] = '{
    {4'd1,  1'b0, 5'h00, 32'h0,        32'h000FFFFF}, // R1
    {4'd1,  1'b0, 5'h04, 32'h0,        32'h000FFFFF}, // R1
    {4'd1,  1'b0, 5'h0C, 32'h0,        32'h00000100}, // R1
    {4'd1,  1'b0, 5'h14, 32'h0,        32'h00000000}, // R1
    {4'd12, 1'b0, 5'h10, 32'h0,        32'h00000003}, // R12
    {4'd1,  1'b0, 5'h08, 32'h0,        32'h00000000}, // R1
    {4'd2,  1'b1, 5'h00, 32'h123,      32'h0},        // R2 locked write
    {4'd2,  1'b0, 5'h00, 32'h0,        32'h000FFFFF},
    {4'd3,  1'b1, 5'h0C, 32'h86,       32'h0},        // R3 second key alone
    {4'd3,  1'b1, 5'h00, 32'h5,        32'h0},
    {4'd3,  1'b0, 5'h00, 32'h0,        32'h000FFFFF},
    {4'd3,  1'b1, 5'h0C, 32'h80,       32'h0},
    {4'd3,  1'b1, 5'h0C, 32'h86,       32'h0},
    {4'd2,  1'b1, 5'h00, 32'hABC12345, 32'h0},        // R2 mask
    {4'd2,  1'b0, 5'h00, 32'h0,        32'h00012345},
    {4'd3,  1'b1, 5'h04, 32'h777,      32'h0},        // R3 key consumed
    {4'd3,  1'b0, 5'h04, 32'h0,        32'h000FFFFF},
    {4'd3,  1'b1, 5'h0C, 32'h80,       32'h0},
    {4'd3,  1'b1, 5'h0C, 32'h86,       32'h0},
    {4'd3,  1'b1, 5'h04, 32'h2,        32'h0},
    {4'd3,  1'b0, 5'h04, 32'h0,        32'h00000002},
    {4'd2,  1'b1, 5'h0C, 32'h80,       32'h0},
    {4'd2,  1'b1, 5'h0C, 32'h86,       32'h0},
    {4'd2,  1'b1, 5'h00, 32'h3,        32'h0},
    {4'd2,  1'b0, 5'h00, 32'h0,        32'h00000003},
    {4'd12, 1'b1, 5'h10, 32'h0,        32'h0},        // R12 irq on, reboot on
    {4'd12, 1'b0, 5'h10, 32'h0,        32'h00000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic keyed_wr(input logic [4:0] a, input logic [31:0] d);
    wr(5'h0C, 32'h80); wr(5'h0C, 32'h86); wr(a, d);
  endtask

  // sel 0: wait for irq_o, sel 1: wait for rst_req_o
  task automatic count_to(input int sel, output int n);
    n = 0;
    while (!(sel == 0 ? irq_o : rst_req_o) && n < 200) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (irq_o) irq_seen = 1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    int pulses;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    chk("R1 irq_o reset", {31'b0, irq_o}, 32'd0);
    chk("R1 rst_req_o reset", {31'b0, rst_req_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][69]) wr(VEC[i][68:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][68:64], v);
        chk($sformatf("R%0d vector %0d", VEC[i][73:70], i), v, VEC[i][31:0]);
      end
    end

    // R5 R6 R7: P1=3, P2=2, prescale 4
    wr(5'h14, 32'h2);
    count_to(0, n);
    chk("R5 stage-1 length", n, 13);
    chk("R6 irq_o after stage 1", {31'b0, irq_o}, 32'd1);
    count_to(1, n);
    chk("R7 stage-2 length", n, 9);
    @(posedge clk); @(negedge clk);
    chk("R7 rst_req_o one cycle", {31'b0, rst_req_o}, 32'd0);
    rd(5'h0C, v);
    chk("R7 sticky set, stage 1", v, 32'h300);
    rd(5'h08, v);
    chk("R10 status active", v, 32'h1);

    // R9 sticky survives system reset
    sys_rst_ni = 1'b0;
    @(posedge clk); @(negedge clk);
    sys_rst_ni = 1'b1;
    chk("R9 irq_o after sys reset", {31'b0, irq_o}, 32'd0);
    rd(5'h0C, v);
    chk("R9 sticky kept", v, 32'h300);
    rd(5'h00, v);
    chk("R9 preload reset by sys reset", v, 32'h000FFFFF);

    // R4 clear sticky
    keyed_wr(5'h0C, 32'h200);
    rd(5'h0C, v);
    chk("R4 sticky cleared", v, 32'h100);

    // R8 reboot disabled, R10 clear
    keyed_wr(5'h00, 32'h3);
    keyed_wr(5'h04, 32'h2);
    wr(5'h10, 32'h20);
    wr(5'h14, 32'h2);
    count_to(0, n);
    chk("R5 stage-1 length again", n, 13);
    wr(5'h08, 32'h1);
    chk("R10 irq_o cleared", {31'b0, irq_o}, 32'd0);
    rd(5'h08, v);
    chk("R10 status cleared", v, 32'h0);
    pulses = 0; irq_seen = 0;
    for (int k = 0; k < 60; k++) begin
      @(posedge clk); @(negedge clk);
      if (rst_req_o) pulses++;
      if (irq_o) irq_seen = 1;
    end
    chk("R8 no reset request", pulses, 0);
    chk("R8 loops back to stage 1", {31'b0, irq_seen}, 32'd1);
    rd(5'h0C, v);
    chk("R8 sticky untouched", v & 32'h200, 32'h0);

    // R4 kick keeps stage 1 alive
    wr(5'h14, 32'h0);
    wr(5'h08, 32'h1);
    chk("R10 irq_o low before kicks", {31'b0, irq_o}, 32'd0);
    wr(5'h14, 32'h2);
    irq_seen = 0;
    for (int k = 0; k < 10; k++) begin
      keyed_wr(5'h0C, 32'h100);
      if (irq_o) irq_seen = 1;
    end
    chk("R4 kicks hold off irq", {31'b0, irq_seen}, 32'd0);
    count_to(0, n);
    chk("R4 restart from stage-1 preload", n, 13);

    // R6 interrupt disabled still reaches stage 2
    wr(5'h14, 32'h0);
    wr(5'h08, 32'h1);
    wr(5'h10, 32'h3);
    wr(5'h14, 32'h2);
    irq_seen = 0;
    count_to(1, n);
    chk("R6 stage 2 reached without irq", n, 22);
    chk("R6 irq_o stays low", {31'b0, irq_seen | irq_o}, 32'd0);
    rd(5'h08, v);
    chk("R10 status masked when disabled", v, 32'h0);

    // R11 lock
    wr(5'h14, 32'h0);
    wr(5'h14, 32'h3);
    wr(5'h14, 32'h0);
    rd(5'h14, v);
    chk("R11 locked write ignored", v, 32'h3);
    count_to(1, n);
    chk("R11 counter unaffected by ignored write", n, 20);

    // R9 power-on reset clears sticky and lock
    rst_ni = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_ni = 1'b1;
    rd(5'h14, v);
    chk("R9 lock cleared by power-on", v, 32'h0);
    rd(5'h0C, v);
    chk("R9 sticky cleared by power-on", v, 32'h100);

    // R11 disable holds, re-enable restarts
    keyed_wr(5'h00, 32'h1);
    wr(5'h10, 32'h0);
    wr(5'h14, 32'h2);
    wr(5'h14, 32'h0);
    pulses = 0; irq_seen = 0;
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); @(negedge clk);
      if (rst_req_o) pulses++;
      if (irq_o) irq_seen = 1;
    end
    chk("R11 disabled: no irq", {31'b0, irq_seen}, 32'd0);
    chk("R11 disabled: no reset", pulses, 0);
    rd(5'h0C, v);
    chk("R11 disabled: still stage 1", v, 32'h100);
    wr(5'h14, 32'h2);
    count_to(0, n);
    chk("R11 enable starts stage 1", n, 5);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule